// File: doc/BRIEF.md
# Address-Request Decode and Admission Stage

This stage stands in front of the address channel of a small interconnect that joins several managers to several subordinates. A request arrives on a single port. It carries the number of the manager slot it came from, a byte address, a thread ID and protection bits. The stage compares the address with a parameter table of address windows. Each target owns one or more windows, and each window is a power-of-two size aligned to that size. A match counts only if the route from that manager to that target is enabled. A non-secure request to a target marked secure is refused.

A request that clears these checks is tagged with the target index. Its ID is widened by placing the manager slot number above the thread ID. A request that finds no usable target is passed on with a decode-error flag and no target. Each target keeps a count of requests in flight. A request to a target whose count has reached its issuing limit is held at the input until a completion pulse from that target lowers the count.

One instance serves one direction, read or write. Each instance is built with that direction's route enables and issuing limits. The outputs are registered behind a valid/ready handshake.

Top module: `xbar_req_admit`

## Requirements
- R1: A window of width W matches when address bits [ADDR_W-1:W] equal the same bits of its base. A target may own up to NUM_RNG windows. `out_tgt` carries the index of the matching target, and the lowest index wins if more than one matches.
- R2: A window whose width entry is 0 is unused and never matches any address, the all-ones address included.
- R3: `out_addr` equals the accepted request's address, unchanged.
- R4: Bit t*NUM_MGR+m of ROUTE_EN enables the route from manager m to target t. A match on a disabled route is treated as no match.
- R5: A request with `req_prot[1]`=1 (non-secure) that targets a target whose SECURE_TGT bit is set is rejected as a decode error. Requests with `req_prot[1]`=0, and requests to non-secure targets, are not affected.
- R6: `out_id` is {req_mgr, req_tid}: the manager slot number sits in the bits above the thread ID.
- R7: A request with no usable target is accepted with `out_decerr`=1 and `out_tgt`=0, and it advances no issuing counter.
- R8: While the selected target's count equals its issuing limit, `req_ready` is 0 and the request is held, not dropped. It is accepted once a completion lowers the count.
- R9: A target's count rises by one on each accepted request to it and falls by one on each `cpl` pulse for it. When both happen in the same cycle, the count is unchanged.
- R10: While `out_valid`=1 and `out_ready`=0, all outputs hold their values and `req_ready` is 0.
- R11: After reset, `out_valid` is 0 and every issuing count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| req_mgr | input | MGR_W | Manager slot number |
| req_addr | input | ADDR_W | Byte address |
| req_tid | input | TID_W | Thread ID |
| req_prot | input | 3 | Protection bits; bit 1 set means non-secure |
| out_valid | output | 1 | Registered result present |
| out_ready | input | 1 | Downstream takes the result |
| out_tgt | output | TGT_W | Selected target index, 0 on decode error |
| out_id | output | MGR_W+TID_W | Extended ID |
| out_addr | output | ADDR_W | Forwarded address |
| out_decerr | output | 1 | No usable target |
| cpl | input | NUM_TGT | One-cycle completion pulse per target |

## Verification
The decoder is driven with a table of addresses chosen to separate its cases: the first and last byte of a window; the byte just past a window; the gap between two windows of one target; a second window of the same target; and the all-ones address, which an unused entry would falsely match if its width were not honoured. The same target is then reached from a manager whose route is disabled and from one whose route is enabled, and a secure target is reached with secure and with non-secure protection. Separate sequences fill a target up to its limit and then free it, complete and accept on the same edge, send decode errors before filling a target, and stall the output.

// File: rtl/xbar_pkg.sv
`timescale 1ns/1ps
package xbar_pkg;
   localparam int CNT_W     = 6;
   localparam int LIMIT_MAX = 32;
   localparam int SLOT_MAX  = 16;

   function automatic int slot_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/xbar_tgt_match.sv
`timescale 1ns/1ps
module xbar_tgt_match #(
   parameter int ADDR_W = 32,
   parameter int NUM_RNG = 2,
   parameter logic [NUM_RNG*64-1:0] BASES = '0,
   parameter logic [NUM_RNG*8-1:0]  WIDTHS = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   logic [NUM_RNG-1:0] rng_hit;

   for (genvar r = 0; r < NUM_RNG; r++) begin : g_rng
      localparam int          W = int'(WIDTHS[r*8 +: 8]);
      localparam logic [63:0] B = BASES[r*64 +: 64];
      if (W == 0) begin : g_unused
         assign rng_hit[r] = 1'b0;
      end else if (W >= ADDR_W) begin : g_whole
         assign rng_hit[r] = 1'b1;
      end else begin : g_cmp
         if (B[W-1:0] != '0) begin : g_bad_align
            $error("window base not aligned to its size");
         end
         assign rng_hit[r] = (addr[ADDR_W-1:W] == B[ADDR_W-1:W]);
      end
   end

   assign hit = |rng_hit;
endmodule

// File: rtl/xbar_issue_ctr.sv
`timescale 1ns/1ps
module xbar_issue_ctr
   import xbar_pkg::*;
#(
   parameter int LIMIT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic             full,
   output logic [CNT_W-1:0] count
);
   logic dec_ok;
   assign dec_ok = dec && (count != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                count <= '0;
      else if (inc && !dec_ok)   count <= count + CNT_W'(1);
      else if (!inc && dec_ok)   count <= count - CNT_W'(1);
   end

   assign full = (count >= CNT_W'(LIMIT));
endmodule

// File: rtl/xbar_req_admit.sv
`timescale 1ns/1ps
module xbar_req_admit
   import xbar_pkg::*;
#(
   parameter int NUM_MGR = 4,
   parameter int NUM_TGT = 3,
   parameter int NUM_RNG = 2,
   parameter int ADDR_W  = 32,
   parameter int TID_W   = 3,
   parameter logic [NUM_TGT*NUM_RNG*64-1:0] RNG_BASE = {
      64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0020_0000,
      64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0010_0000,
      64'h0000_0000_0001_0000, 64'h0000_0000_0000_0000},
   parameter logic [NUM_TGT*NUM_RNG*8-1:0] RNG_WIDTH = {
      8'd0, 8'd20, 8'd0, 8'd12, 8'd16, 8'd12},
   parameter logic [NUM_TGT*NUM_MGR-1:0] ROUTE_EN = 12'b1111_0111_1111,
   parameter logic [NUM_TGT-1:0] SECURE_TGT = 3'b100,
   parameter logic [NUM_TGT*CNT_W-1:0] ISSUE_LIMIT = {6'd4, 6'd1, 6'd2},
   localparam int MGR_W = slot_bits(NUM_MGR),
   localparam int TGT_W = slot_bits(NUM_TGT),
   localparam int OID_W = MGR_W + TID_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [MGR_W-1:0]   req_mgr,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [TID_W-1:0]   req_tid,
   input  logic [2:0]         req_prot,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [TGT_W-1:0]   out_tgt,
   output logic [OID_W-1:0]   out_id,
   output logic [ADDR_W-1:0]  out_addr,
   output logic               out_decerr,
   input  logic [NUM_TGT-1:0] cpl
);
   localparam int MGR_N = 1 << MGR_W;
   localparam int TGT_N = 1 << TGT_W;

   if (NUM_MGR < 1 || NUM_MGR > SLOT_MAX) begin : g_bad_mgr
      $error("NUM_MGR must be 1..16");
   end
   if (NUM_TGT < 1 || NUM_TGT > SLOT_MAX) begin : g_bad_tgt
      $error("NUM_TGT must be 1..16");
   end
   if (NUM_RNG < 1 || NUM_RNG > SLOT_MAX) begin : g_bad_rng
      $error("NUM_RNG must be 1..16");
   end
   if (ADDR_W < 1 || ADDR_W > 64 || TID_W < 1) begin : g_bad_width
      $error("ADDR_W must be 1..64 and TID_W at least 1");
   end

   logic [NUM_TGT-1:0]       tgt_hit;
   logic [NUM_TGT-1:0]       full_vec;
   logic [NUM_TGT-1:0]       inc_vec;
   logic [NUM_TGT*CNT_W-1:0] issue_cnt;
   logic [TGT_N-1:0]         full_pad;
   logic [TGT_W-1:0]         sel;
   logic                     dec_err, admit, accept;

   for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
      localparam int               LIM    = int'(ISSUE_LIMIT[t*CNT_W +: CNT_W]);
      localparam logic [MGR_N-1:0] ROUTES = MGR_N'(ROUTE_EN[t*NUM_MGR +: NUM_MGR]);
      logic addr_hit, route_ok, sec_ok;

      if (LIM < 1 || LIM > LIMIT_MAX) begin : g_bad_lim
         $error("issuing limit must be 1..32");
      end

      xbar_tgt_match #(
         .ADDR_W (ADDR_W),
         .NUM_RNG(NUM_RNG),
         .BASES  (RNG_BASE[t*NUM_RNG*64 +: NUM_RNG*64]),
         .WIDTHS (RNG_WIDTH[t*NUM_RNG*8 +: NUM_RNG*8])
      ) u_match (
         .addr(req_addr),
         .hit (addr_hit)
      );

      assign route_ok = ROUTES[req_mgr];

      if (SECURE_TGT[t]) begin : g_secure
         assign sec_ok = ~req_prot[1];
      end else begin : g_open
         assign sec_ok = 1'b1;
      end

      assign tgt_hit[t] = addr_hit & route_ok & sec_ok;
      assign inc_vec[t] = accept & ~dec_err & (sel == TGT_W'(t));

      xbar_issue_ctr #(.LIMIT(LIM)) u_ctr (
         .clk  (clk),
         .rst_n(rst_n),
         .inc  (inc_vec[t]),
         .dec  (cpl[t]),
         .full (full_vec[t]),
         .count(issue_cnt[t*CNT_W +: CNT_W])
      );
   end

   always_comb begin
      sel = '0;
      for (int t = NUM_TGT - 1; t >= 0; t--) begin
         if (tgt_hit[t]) sel = TGT_W'(t);
      end
   end

   assign dec_err   = ~|tgt_hit;
   assign full_pad  = TGT_N'(full_vec);
   assign admit     = dec_err | ~full_pad[sel];
   assign req_ready = (~out_valid | out_ready) & admit;
   assign accept    = req_valid & req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_tgt    <= '0;
         out_id     <= '0;
         out_addr   <= '0;
         out_decerr <= 1'b0;
      end else if (accept) begin
         out_valid  <= 1'b1;
         out_tgt    <= sel;
         out_id     <= {req_mgr, req_tid};
         out_addr   <= req_addr;
         out_decerr <= dec_err;
      end else if (out_ready) begin
         out_valid  <= 1'b0;
      end
   end
endmodule

// File: rtl/xbar_req_admit_chk.sv
`timescale 1ns/1ps
module xbar_req_admit_chk
   import xbar_pkg::*;
#(
   parameter int NUM_TGT = 3,
   parameter int ADDR_W  = 32,
   parameter int TID_W   = 3,
   parameter int MGR_W   = 2,
   parameter int TGT_W   = 2,
   parameter logic [NUM_TGT*CNT_W-1:0] ISSUE_LIMIT = '0
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     req_valid,
   input logic                     req_ready,
   input logic [MGR_W-1:0]         req_mgr,
   input logic [ADDR_W-1:0]        req_addr,
   input logic [TID_W-1:0]         req_tid,
   input logic                     out_valid,
   input logic                     out_ready,
   input logic [TGT_W-1:0]         out_tgt,
   input logic [MGR_W+TID_W-1:0]   out_id,
   input logic [ADDR_W-1:0]        out_addr,
   input logic                     out_decerr,
   input logic [NUM_TGT*CNT_W-1:0] issue_cnt
);
   logic took;
   assign took = req_valid & req_ready;

   AST_ADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      took |=> out_valid && out_addr == $past(req_addr)); // R3
   AST_ID_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
      took |=> out_id == {$past(req_mgr), $past(req_tid)}); // R6
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_id) && $stable(out_addr)
                                  && $stable(out_tgt) && $stable(out_decerr)); // R10
   AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !req_ready); // R10
   AST_DECERR_TGT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_decerr |-> out_tgt == '0); // R7
   AST_TGT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_decerr |-> int'(out_tgt) < NUM_TGT); // R1

   for (genvar t = 0; t < NUM_TGT; t++) begin : g_cnt
      logic [CNT_W-1:0] cnt_t;
      assign cnt_t = issue_cnt[t*CNT_W +: CNT_W];
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_t <= ISSUE_LIMIT[t*CNT_W +: CNT_W]); // R8
   end
endmodule

bind xbar_req_admit xbar_req_admit_chk #(
   .NUM_TGT    (NUM_TGT),
   .ADDR_W     (ADDR_W),
   .TID_W      (TID_W),
   .MGR_W      (MGR_W),
   .TGT_W      (TGT_W),
   .ISSUE_LIMIT(ISSUE_LIMIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_mgr   (req_mgr),
   .req_addr  (req_addr),
   .req_tid   (req_tid),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_tgt   (out_tgt),
   .out_id    (out_id),
   .out_addr  (out_addr),
   .out_decerr(out_decerr),
   .issue_cnt (issue_cnt)
);

// File: tb/xbar_req_admit_tb.sv
`timescale 1ns/1ps
module xbar_req_admit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_mgr = '0;
   logic [31:0] req_addr = '0;
   logic [2:0]  req_tid = '0;
   logic [2:0]  req_prot = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [1:0]  out_tgt;
   logic [4:0]  out_id;
   logic [31:0] out_addr;
   logic        out_decerr;
   logic [2:0]  cpl = '0;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   xbar_req_admit u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_mgr(req_mgr), .req_addr(req_addr), .req_tid(req_tid), .req_prot(req_prot),
      .out_valid(out_valid), .out_ready(out_ready), .out_tgt(out_tgt), .out_id(out_id),
      .out_addr(out_addr), .out_decerr(out_decerr), .cpl(cpl)
   );

   // entry: {mgr[39:38], addr[37:6], prot[5:3], decerr[2], tgt[1:0]}
   localparam int NV = 12;
   localparam logic [39:0] VEC [NV] = '{
      {2'd0, 32'h0000_0123, 3'd0, 1'b0, 2'd0},  // R1 first window of target 0
      {2'd1, 32'h0001_ABCD, 3'd2, 1'b0, 2'd0},  // R1 second window; R5 non-secure target
      {2'd2, 32'h0010_0FFC, 3'd0, 1'b0, 2'd1},  // R1 top of target 1
      {2'd0, 32'h0010_1000, 3'd0, 1'b1, 2'd0},  // R1 one byte past the window
      {2'd1, 32'h0020_0000, 3'd0, 1'b0, 2'd2},  // R5 secure access to secure target
      {2'd1, 32'h002F_FFFF, 3'd2, 1'b1, 2'd0},  // R5 non-secure access refused
      {2'd3, 32'h0010_0004, 3'd0, 1'b1, 2'd0},  // R4 disabled route
      {2'd2, 32'h0010_0004, 3'd0, 1'b0, 2'd1},  // R4 enabled route
      {2'd0, 32'hFFFF_FFFF, 3'd0, 1'b1, 2'd0},  // R2 unused entries never match
      {2'd3, 32'h0000_0FFF, 3'd1, 1'b0, 2'd0},  // R1 last byte of window
      {2'd0, 32'h0000_1000, 3'd0, 1'b1, 2'd0},  // R1 gap between windows
      {2'd3, 32'h002A_0000, 3'd1, 1'b0, 2'd2}   // R1 wide window, secure ok
   };

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] m, input logic [31:0] a, input logic [2:0] id,
                        input logic [2:0] p);
      @(negedge clk);
      req_mgr = m; req_addr = a; req_tid = id; req_prot = p; req_valid = 1'b1;
      #1;
   endtask

   // drive a request, sample ready, step to next negedge, drop valid
   task automatic try_req(input logic [1:0] m, input logic [31:0] a, input logic [2:0] id,
                          input logic [2:0] p, output bit acc);
      drive(m, a, id, p);
      acc = req_ready;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic pulse(input int t);
      @(negedge clk);
      cpl[t] = 1'b1;
      @(negedge clk);
      cpl = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      bit acc;
      // R11 reset state
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R11 out_valid in reset", 64'(out_valid), 64'd0);
      rst_n = 1'b1;
      drive(2'd0, 32'h0010_0000, 3'd0, 3'd0);
      check(req_ready == 1'b1, "R11 count zero after reset", 64'(req_ready), 64'd1);
      @(negedge clk); req_valid = 1'b0;
      pulse(1);

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [39:0] v;
         v = VEC[i];
         try_req(v[39:38], v[37:6], 3'(i), v[5:3], acc);
         check(acc && out_valid, $sformatf("R8 vec %0d accepted", i), 64'(acc), 64'd1);
         check(out_decerr == v[2] && out_tgt == v[1:0],
               $sformatf("R1 R2 R4 R5 R7 vec %0d decode", i),
               64'({out_decerr, out_tgt}), 64'(v[2:0]));
         check(out_id == {v[39:38], 3'(i)}, $sformatf("R6 vec %0d id", i),
               64'(out_id), 64'({v[39:38], 3'(i)}));
         check(out_addr == v[37:6], $sformatf("R3 vec %0d addr", i),
               64'(out_addr), 64'(v[37:6]));
         if (!v[2]) pulse(int'(v[1:0]));
      end

      // R10 output stall
      out_ready = 1'b0;
      try_req(2'd1, 32'h0000_0040, 3'd5, 3'd0, acc);
      drive(2'd2, 32'h0000_0080, 3'd6, 3'd0);
      check(req_ready == 1'b0, "R10 ready low while stalled", 64'(req_ready), 64'd0);
      @(negedge clk);
      check(out_valid && out_id == {2'd1, 3'd5} && out_addr == 32'h40,
            "R10 output held", 64'(out_id), 64'({2'd1, 3'd5}));
      out_ready = 1'b1;
      #1;
      check(req_ready == 1'b1, "R10 ready after release", 64'(req_ready), 64'd1);
      @(negedge clk);
      req_valid = 1'b0;
      check(out_id == {2'd2, 3'd6}, "R10 second request taken", 64'(out_id),
            64'({2'd2, 3'd6}));
      pulse(0); pulse(0);

      // R8 limit on target 1 (limit 1)
      try_req(2'd0, 32'h0010_0010, 3'd1, 3'd0, acc);
      drive(2'd0, 32'h0010_0020, 3'd2, 3'd0);
      check(req_ready == 1'b0, "R8 held at limit", 64'(req_ready), 64'd0);
      @(negedge clk);
      check(req_ready == 1'b0 && out_valid == 1'b0, "R8 still held, nothing issued",
            64'({req_ready, out_valid}), 64'd0);
      cpl[1] = 1'b1;
      @(negedge clk);
      cpl = '0;
      #1;
      check(req_ready == 1'b1, "R8 released by completion", 64'(req_ready), 64'd1);
      @(negedge clk);
      req_valid = 1'b0;
      check(out_valid && out_tgt == 2'd1 && out_addr == 32'h0010_0020,
            "R8 held request issued", 64'(out_addr), 64'h0010_0020);
      pulse(1);

      // R9 accept and complete on one edge, target 0 (limit 2)
      try_req(2'd0, 32'h0000_0000, 3'd0, 3'd0, acc);
      drive(2'd0, 32'h0000_0004, 3'd1, 3'd0);
      cpl[0] = 1'b1;
      @(negedge clk);
      cpl = '0;
      req_addr = 32'h0000_0008;
      #1;
      check(req_ready == 1'b1, "R9 count unchanged after inc+dec", 64'(req_ready), 64'd1);
      @(negedge clk);
      #1;
      check(req_ready == 1'b0, "R9 count reaches limit", 64'(req_ready), 64'd0);
      req_valid = 1'b0;
      pulse(0); pulse(0);

      // R7 decode errors do not advance a counter
      try_req(2'd0, 32'h00FF_0000, 3'd0, 3'd0, acc);
      try_req(2'd1, 32'h00FF_0004, 3'd0, 3'd0, acc);
      check(out_decerr == 1'b1 && out_tgt == 2'd0, "R7 decode error output",
            64'({out_decerr, out_tgt}), 64'h4);
      try_req(2'd0, 32'h0000_0010, 3'd0, 3'd0, acc);
      check(acc == 1'b1, "R7 first after errors", 64'(acc), 64'd1);
      try_req(2'd0, 32'h0000_0014, 3'd0, 3'd0, acc);
      check(acc == 1'b1, "R7 second after errors", 64'(acc), 64'd1);
      pulse(0); pulse(0);

      repeat (2) @(negedge clk);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule